// File: doc/BRIEF.md
# Processor Memory Map Decoder

This block turns the address, function code, transfer size and strobes of an asynchronous 32-bit processor bus into device selects. The most significant address byte picks a region: a large DRAM window in the lower half of the address space, four expansion slot windows of 16 MB each, one window for onboard peripherals and one for a 16-bit flash. Inside the peripheral window, address bits 19:16 pick one of sixteen devices. A CPU-space cycle is not decoded as memory. Only the floating-point coprocessor is recognised in CPU space, and every other CPU-space cycle is left to other logic.

For each decoded region the block returns the two-line data-size acknowledge that matches the port width of the selected device. It asserts bus error for an address that maps to nothing. Expansion slots receive separate upper and lower byte selects, built from address bit 0 and the size bits and gated by the data strobe. Software sets each slot's port width through a small synchronous configuration port, so a card can sit in any slot. The decode path itself is combinational from the bus pins. Every select and acknowledge therefore falls as soon as the address strobe is negated.

Top module: `memmap_decoder`

## Requirements
- R1: With `as_n` low and `fc` not 3'b111, a top address byte from 0x00 to 0x7F drives only `dram_cs_n` low, with `dsack_n` = 2'b00 (32-bit port).
- R2: With `fc` not 3'b111, a top byte of 0x80 + n (n = 0..3) selects slot n: only that slot's `slot_ucs_n[n]`/`slot_lcs_n[n]` may go low, and every other select stays high.
- R3: Top byte 0x84 drives exactly `periph_cs_n[addr_dev]` low, with `dsack_n` = 2'b10 (8-bit port).
- R4: Top byte 0xFF drives only `flash_cs_n` low, with `dsack_n` = 2'b01 (16-bit port).
- R5: When `fc` = 3'b111 and `addr_dev` = 4'b0010, only `cop_cs_n` is driven low, with `dsack_n` = 2'b00, whatever the top byte is. Any other CPU-space cycle drives no select, no acknowledge and no bus error.
- R6: The size codes are `siz` 01 = byte, 10 = word, 11 = three bytes and 00 = long. A slot's upper select is low unless the transfer is a byte at an odd address (`addr_a0` = 1). Its lower select is low for a byte at an odd address and for every transfer other than a byte. Both selects stay high while `ds_n` is high.
- R7: The acknowledge encoding `dsack_n` = {DSACK1, DSACK0} is 2'b00 for a 32-bit port, 2'b01 for a 16-bit port and 2'b10 for an 8-bit port.
- R8: Each slot holds a width code: 00 = 8-bit, 01 = 16-bit, 10 or 11 = 32-bit. After reset every slot holds 01. A slot access returns the acknowledge for the width code that slot currently holds.
- R9: Top bytes 0x85 to 0xFE outside CPU space drive `berr_n` low, keep `dsack_n` = 2'b11 and drive no select.
- R10: While `as_n` is high, every select, both acknowledge lines and `berr_n` are high.
- R11: A configuration write (`cfg_we` high at a rising clock edge) stores `cfg_width` for slot `cfg_slot`. An access to that slot in the same cycle still returns the old width, and the new width applies from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the slot width registers |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_hi | input | 8 | Address bits 31:24 |
| addr_dev | input | 4 | Address bits 19:16 |
| addr_a0 | input | 1 | Address bit 0 |
| fc | input | 3 | Function code |
| siz | input | 2 | Transfer size code |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| cfg_we | input | 1 | Slot width write enable |
| cfg_slot | input | 2 | Slot being configured |
| cfg_width | input | 2 | Width code to store |
| dram_cs_n | output | 1 | DRAM region select |
| flash_cs_n | output | 1 | Flash select |
| cop_cs_n | output | 1 | Coprocessor select |
| periph_cs_n | output | 16 | Onboard device selects |
| slot_ucs_n | output | 4 | Slot upper byte selects |
| slot_lcs_n | output | 4 | Slot lower byte selects |
| dsack_n | output | 2 | Data-size acknowledge {DSACK1, DSACK0} |
| berr_n | output | 1 | Bus error for unmapped addresses |

## Verification
Two functions can fall in the same cycle: a slot access that reads the slot's width for its acknowledge, and a configuration write that changes that same width. The bench holds an access to slot 3 and raises `cfg_we` for slot 3 in the same low clock phase. It first checks that the acknowledge still shows the old 16-bit code before the edge, then checks that it shows the new 8-bit code after the edge. Releasing the address strobe in the middle of an access is also checked, and every output must go high at once.

// File: rtl/memmap_pkg.sv
// Package: shared types and helpers for the memory map decoder.
// Assumes a two-line data-size acknowledge, active low, ordered {DSACK1, DSACK0}.
package memmap_pkg;

    // Port width code as stored per slot.
    typedef enum logic [1:0] {
        PW_BYTE     = 2'b00,
        PW_WORD     = 2'b01,
        PW_LONG     = 2'b10,
        PW_LONG_ALT = 2'b11
    } port_width_e;

    // Region picked by the address decode.
    typedef enum logic [2:0] {
        RG_NONE     = 3'd0,
        RG_DRAM     = 3'd1,
        RG_SLOT     = 3'd2,
        RG_PERIPH   = 3'd3,
        RG_FLASH    = 3'd4,
        RG_COP      = 3'd5,
        RG_UNMAPPED = 3'd6
    } region_e;

    // Map a port width to the active-low acknowledge pair.
    function automatic logic [1:0] width_to_ack(port_width_e w);
        case (w)
            PW_BYTE: return 2'b10;
            PW_WORD: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/memmap_region.sv
// Module: memmap_region
// Purely combinational classification of a bus cycle into a region.
// Assumes a CPU-space cycle is marked by the all-ones function code and
// that a CPU-space cycle never addresses memory.
module memmap_region
    import memmap_pkg::*;
#(
    parameter int          NUM_SLOTS  = 4,
    parameter int          DEV_W      = 4,
    parameter logic [7:0]  SLOT_BASE  = 8'h80,
    parameter logic [7:0]  PERIPH_TOP = 8'h84,
    parameter logic [7:0]  FLASH_TOP  = 8'hFF,
    parameter logic [DEV_W-1:0] COP_ID = 4'h2,
    localparam int         SIDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [7:0]        addr_hi,
    input  logic [DEV_W-1:0]  addr_dev,
    input  logic [2:0]        fc,
    output region_e           region,
    output logic [SIDX_W-1:0] slot_idx
);

    logic [7:0] slot_off;
    logic       cpu_space;

    // Offset of the top byte from the first slot window.
    always_comb slot_off = addr_hi - SLOT_BASE;

    // CPU-space cycles use the all-ones function code.
    always_comb cpu_space = (fc == 3'b111);

    // Slot number inside the slot windows.
    always_comb slot_idx = slot_off[SIDX_W-1:0];

    // Region priority: CPU space, DRAM half, slots, peripherals, flash.
    always_comb begin
        if (cpu_space) begin
            region = (addr_dev == COP_ID) ? RG_COP : RG_NONE;
        end else if (!addr_hi[7]) begin
            region = RG_DRAM;
        end else if (slot_off < 8'(NUM_SLOTS)) begin
            region = RG_SLOT;
        end else if (addr_hi == PERIPH_TOP) begin
            region = RG_PERIPH;
        end else if (addr_hi == FLASH_TOP) begin
            region = RG_FLASH;
        end else begin
            region = RG_UNMAPPED;
        end
    end

endmodule

// File: rtl/memmap_slot_width.sv
// Module: memmap_slot_width
// One width register per expansion slot, written through a synchronous
// configuration port. Assumes one write per clock at most.
module memmap_slot_width
    import memmap_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    localparam int SIDX_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SIDX_W-1:0] cfg_slot,
    input  logic [1:0]        cfg_width,
    input  logic [SIDX_W-1:0] rd_slot,
    output port_width_e       rd_width
);

    port_width_e width_q [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // Hold or update the width code of slot g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                width_q[g] <= PW_WORD;
            end else if (cfg_we && (cfg_slot == SIDX_W'(g))) begin
                width_q[g] <= port_width_e'(cfg_width);
            end
        end

        AST_WIDTH_STORED: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_slot == SIDX_W'(g)) |=> (width_q[g] == port_width_e'($past(cfg_width)))); // R11

        AST_WIDTH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && cfg_slot == SIDX_W'(g)) |=> $stable(width_q[g])); // R8
    end

    // Read port for the slot currently addressed.
    always_comb rd_width = width_q[rd_slot];

endmodule

// File: rtl/memmap_lanes.sv
// Module: memmap_lanes
// Upper and lower byte selects for a 16-bit slot port, from address bit 0
// and the size code. Assumes size 01 = byte, everything else covers both
// lanes of the addressed word.
module memmap_lanes #(
    parameter int NUM_SLOTS = 4
) (
    input  logic [NUM_SLOTS-1:0] slot_hit,
    input  logic                 strobe_ok,
    input  logic                 addr_a0,
    input  logic [1:0]           siz,
    output logic [NUM_SLOTS-1:0] ucs_n,
    output logic [NUM_SLOTS-1:0] lcs_n
);

    logic is_byte;
    logic want_upper;
    logic want_lower;

    // Lane needs of the current transfer.
    always_comb begin
        is_byte    = (siz == 2'b01);
        want_upper = !(is_byte && addr_a0);
        want_lower = addr_a0 || !is_byte;
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_lane
        // Gate the lane needs with the slot hit and the strobes.
        always_comb begin
            ucs_n[g] = !(slot_hit[g] && strobe_ok && want_upper);
            lcs_n[g] = !(slot_hit[g] && strobe_ok && want_lower);
        end
    end

endmodule

// File: rtl/memmap_decoder.sv
// Module: memmap_decoder (top)
// Chip selects, byte-lane selects, data-size acknowledge and bus error for
// a 32-bit asynchronous processor bus. Decode is combinational from the bus
// pins; only the slot width registers are clocked.
// Assumes a single bus master and that as_n frames each cycle.
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int DEV_W     = 4,
    localparam int SIDX_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int NUM_DEV  = 1 << DEV_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           addr_hi,
    input  logic [DEV_W-1:0]     addr_dev,
    input  logic                 addr_a0,
    input  logic [2:0]           fc,
    input  logic [1:0]           siz,
    input  logic                 as_n,
    input  logic                 ds_n,
    input  logic                 cfg_we,
    input  logic [SIDX_W-1:0]    cfg_slot,
    input  logic [1:0]           cfg_width,
    output logic                 dram_cs_n,
    output logic                 flash_cs_n,
    output logic                 cop_cs_n,
    output logic [NUM_DEV-1:0]   periph_cs_n,
    output logic [NUM_SLOTS-1:0] slot_ucs_n,
    output logic [NUM_SLOTS-1:0] slot_lcs_n,
    output logic [1:0]           dsack_n,
    output logic                 berr_n
);

    region_e              region;
    logic [SIDX_W-1:0]    slot_idx;
    port_width_e          slot_width;
    logic                 active;
    logic [NUM_SLOTS-1:0] slot_hit;
    port_width_e          port_width;

    memmap_region #(
        .NUM_SLOTS (NUM_SLOTS),
        .DEV_W     (DEV_W)
    ) region_i (
        .addr_hi  (addr_hi),
        .addr_dev (addr_dev),
        .fc       (fc),
        .region   (region),
        .slot_idx (slot_idx)
    );

    memmap_slot_width #(
        .NUM_SLOTS (NUM_SLOTS)
    ) width_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_slot  (cfg_slot),
        .cfg_width (cfg_width),
        .rd_slot   (slot_idx),
        .rd_width  (slot_width)
    );

    // A cycle is live only while the address strobe is asserted.
    always_comb active = !as_n;

    // One-hot slot hit for the lane logic.
    always_comb begin
        slot_hit = '0;
        if (active && region == RG_SLOT) slot_hit[slot_idx] = 1'b1;
    end

    memmap_lanes #(
        .NUM_SLOTS (NUM_SLOTS)
    ) lanes_i (
        .slot_hit  (slot_hit),
        .strobe_ok (active && !ds_n),
        .addr_a0   (addr_a0),
        .siz       (siz),
        .ucs_n     (slot_ucs_n),
        .lcs_n     (slot_lcs_n)
    );

    // Whole-region selects.
    always_comb begin
        dram_cs_n   = !(active && region == RG_DRAM);
        flash_cs_n  = !(active && region == RG_FLASH);
        cop_cs_n    = !(active && region == RG_COP);
        periph_cs_n = '1;
        if (active && region == RG_PERIPH) periph_cs_n[addr_dev] = 1'b0;
    end

    // Port width of the decoded region.
    always_comb begin
        case (region)
            RG_SLOT:   port_width = slot_width;
            RG_FLASH:  port_width = PW_WORD;
            RG_PERIPH: port_width = PW_BYTE;
            default:   port_width = PW_LONG;
        endcase
    end

    // Acknowledge for mapped regions, bus error for unmapped ones.
    always_comb begin
        dsack_n = 2'b11;
        berr_n  = 1'b1;
        if (active) begin
            case (region)
                RG_NONE:     dsack_n = 2'b11;
                RG_UNMAPPED: berr_n  = 1'b0;
                default:     dsack_n = width_to_ack(port_width);
            endcase
        end
    end

    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~dram_cs_n, ~flash_cs_n, ~cop_cs_n, ~periph_cs_n,
                  ~(slot_ucs_n & slot_lcs_n)})); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> (dsack_n == 2'b11 && berr_n && dram_cs_n && flash_cs_n
                  && cop_cs_n && (&periph_cs_n) && (&slot_ucs_n) && (&slot_lcs_n))); // R10

    AST_BERR_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !berr_n |-> (dsack_n == 2'b11)); // R9

    AST_COP_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        !cop_cs_n |-> (dsack_n == 2'b00 && fc == 3'b111)); // R5

    AST_PERIPH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !(&periph_cs_n) |-> (dsack_n == 2'b10 && $countones(~periph_cs_n) == 1)); // R3

    AST_LANES_NEED_DS: assert property (@(posedge clk) disable iff (!rst_n)
        ds_n |-> ((&slot_ucs_n) && (&slot_lcs_n))); // R6

    AST_FLASH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_cs_n |-> (dsack_n == 2'b01)); // R4

    AST_DRAM_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cs_n |-> (dsack_n == 2'b00 && !addr_hi[7])); // R1

endmodule

// File: tb/memmap_decoder_tb.sv
module memmap_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  addr_hi;
    logic [3:0]  addr_dev;
    logic        addr_a0;
    logic [2:0]  fc;
    logic [1:0]  siz;
    logic        as_n, ds_n;
    logic        cfg_we;
    logic [1:0]  cfg_slot, cfg_width;
    logic        dram_cs_n, flash_cs_n, cop_cs_n, berr_n;
    logic [15:0] periph_cs_n;
    logic [3:0]  slot_ucs_n, slot_lcs_n;
    logic [1:0]  dsack_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    memmap_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .addr_dev(addr_dev),
        .addr_a0(addr_a0), .fc(fc), .siz(siz), .as_n(as_n), .ds_n(ds_n),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_width(cfg_width),
        .dram_cs_n(dram_cs_n), .flash_cs_n(flash_cs_n), .cop_cs_n(cop_cs_n),
        .periph_cs_n(periph_cs_n), .slot_ucs_n(slot_ucs_n),
        .slot_lcs_n(slot_lcs_n), .dsack_n(dsack_n), .berr_n(berr_n)
    );

    // Packed view {dram, flash, cop, periph[15:0], ucs[3:0], lcs[3:0], dsack[1:0], berr}.
    function automatic logic [29:0] pack_exp(logic d, logic f, logic c, logic [15:0] p,
                                             logic [3:0] u, logic [3:0] l,
                                             logic [1:0] k, logic b);
        return {d, f, c, p, u, l, k, b};
    endfunction

    localparam logic [29:0] QUIET = 30'h3FFF_FFFF;

    function automatic logic [29:0] observed();
        return {dram_cs_n, flash_cs_n, cop_cs_n, periph_cs_n, slot_ucs_n,
                slot_lcs_n, dsack_n, berr_n};
    endfunction

    task automatic check(string tag, logic [29:0] act, logic [29:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one bus cycle at a falling edge and let the decode settle.
    task automatic drive(logic [7:0] hi, logic [3:0] dev, logic a0,
                         logic [2:0] f, logic [1:0] s, logic a, logic d);
        @(negedge clk);
        addr_hi = hi; addr_dev = dev; addr_a0 = a0; fc = f; siz = s;
        as_n = a; ds_n = d;
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        as_n = 1'b1; ds_n = 1'b1;
        #2;
    endtask

    task automatic write_width(logic [1:0] slot, logic [1:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = slot; cfg_width = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 reset quiet", observed(), QUIET);
        drive(8'h80, 4'h0, 1'b0, 3'b001, 2'b10, 1'b0, 1'b0);
        check("R8 reset width word", observed(),
              pack_exp(1, 1, 1, 16'hFFFF, 4'b1110, 4'b1110, 2'b01, 1));
        idle();
    endtask

    task automatic t_dram();
        drive(8'h00, 4'h3, 1'b0, 3'b101, 2'b00, 1'b0, 1'b0);
        check("R1 dram low edge", observed(), pack_exp(0, 1, 1, 16'hFFFF, 4'hF, 4'hF, 2'b00, 1));
        drive(8'h7F, 4'h2, 1'b1, 3'b010, 2'b01, 1'b0, 1'b0);
        check("R7 dram high edge long ack", observed(), pack_exp(0, 1, 1, 16'hFFFF, 4'hF, 4'hF, 2'b00, 1));
        idle();
    endtask

    task automatic t_slots();
        for (int s = 0; s < 4; s++) begin
            drive(8'h80 + 8'(s), 4'h0, 1'b0, 3'b001, 2'b10, 1'b0, 1'b1);
            check("R6 no lanes before ds", observed(), pack_exp(1, 1, 1, 16'hFFFF, 4'hF, 4'hF, 2'b01, 1));
            drive(8'h80 + 8'(s), 4'h0, 1'b0, 3'b001, 2'b10, 1'b0, 1'b0);
            check("R2 slot select", observed(),
                  pack_exp(1, 1, 1, 16'hFFFF, ~(4'b1 << s), ~(4'b1 << s), 2'b01, 1));
            idle();
        end
    endtask

    task automatic t_lanes();
        drive(8'h81, 4'h0, 1'b0, 3'b001, 2'b01, 1'b0, 1'b0);
        check("R6 even byte", observed(), pack_exp(1, 1, 1, 16'hFFFF, 4'b1101, 4'b1111, 2'b01, 1));
        drive(8'h81, 4'h0, 1'b1, 3'b001, 2'b01, 1'b0, 1'b0);
        check("R6 odd byte", observed(), pack_exp(1, 1, 1, 16'hFFFF, 4'b1111, 4'b1101, 2'b01, 1));
        drive(8'h81, 4'h0, 1'b0, 3'b001, 2'b00, 1'b0, 1'b0);
        check("R6 long", observed(), pack_exp(1, 1, 1, 16'hFFFF, 4'b1101, 4'b1101, 2'b01, 1));
        drive(8'h81, 4'h0, 1'b1, 3'b001, 2'b11, 1'b0, 1'b0);
        check("R6 three bytes odd", observed(), pack_exp(1, 1, 1, 16'hFFFF, 4'b1101, 4'b1101, 2'b01, 1));
        idle();
    endtask

    task automatic t_periph();
        for (int d = 0; d < 16; d += 5) begin
            drive(8'h84, 4'(d), 1'b0, 3'b101, 2'b01, 1'b0, 1'b0);
            check("R3 periph device", observed(),
                  pack_exp(1, 1, 1, ~(16'b1 << d), 4'hF, 4'hF, 2'b10, 1));
        end
        idle();
    endtask

    task automatic t_flash();
        drive(8'hFF, 4'hF, 1'b0, 3'b110, 2'b10, 1'b0, 1'b0);
        check("R4 flash word ack", observed(), pack_exp(1, 0, 1, 16'hFFFF, 4'hF, 4'hF, 2'b01, 1));
        idle();
    endtask

    task automatic t_cop();
        drive(8'h84, 4'h2, 1'b0, 3'b111, 2'b00, 1'b0, 1'b0);
        check("R5 coprocessor", observed(), pack_exp(1, 1, 0, 16'hFFFF, 4'hF, 4'hF, 2'b00, 1));
        drive(8'h90, 4'h6, 1'b0, 3'b111, 2'b00, 1'b0, 1'b0);
        check("R5 other cpu space silent", observed(), QUIET);
        idle();
    endtask

    task automatic t_unmapped();
        drive(8'h85, 4'h0, 1'b0, 3'b001, 2'b10, 1'b0, 1'b0);
        check("R9 unmapped low", observed(), pack_exp(1, 1, 1, 16'hFFFF, 4'hF, 4'hF, 2'b11, 0));
        drive(8'hFE, 4'h2, 1'b0, 3'b101, 2'b10, 1'b0, 1'b0);
        check("R9 unmapped high", observed(), pack_exp(1, 1, 1, 16'hFFFF, 4'hF, 4'hF, 2'b11, 0));
        idle();
    endtask

    task automatic t_width();
        write_width(2'd2, 2'b00);
        write_width(2'd1, 2'b11);
        drive(8'h82, 4'h0, 1'b0, 3'b001, 2'b10, 1'b0, 1'b0);
        check("R8 slot2 byte port", observed(), pack_exp(1, 1, 1, 16'hFFFF, 4'b1011, 4'b1011, 2'b10, 1));
        drive(8'h81, 4'h0, 1'b0, 3'b001, 2'b10, 1'b0, 1'b0);
        check("R8 slot1 long port", observed(), pack_exp(1, 1, 1, 16'hFFFF, 4'b1101, 4'b1101, 2'b00, 1));
        drive(8'h80, 4'h0, 1'b0, 3'b001, 2'b10, 1'b0, 1'b0);
        check("R8 slot0 unchanged", observed(), pack_exp(1, 1, 1, 16'hFFFF, 4'b1110, 4'b1110, 2'b01, 1));
        idle();
    endtask

    task automatic t_same_cycle();
        drive(8'h83, 4'h0, 1'b0, 3'b001, 2'b10, 1'b0, 1'b0);
        cfg_we = 1'b1; cfg_slot = 2'd3; cfg_width = 2'b00;
        #2;
        check("R11 old width before edge", observed(),
              pack_exp(1, 1, 1, 16'hFFFF, 4'b0111, 4'b0111, 2'b01, 1));
        @(posedge clk);
        #2;
        check("R11 new width after edge", observed(),
              pack_exp(1, 1, 1, 16'hFFFF, 4'b0111, 4'b0111, 2'b10, 1));
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_release();
        drive(8'h83, 4'h0, 1'b0, 3'b001, 2'b00, 1'b0, 1'b0);
        as_n = 1'b1;
        #1;
        check("R10 release mid cycle", observed(), QUIET);
        idle();
    endtask

    initial begin
        rst_n = 1'b0; addr_hi = 8'h00; addr_dev = 4'h0; addr_a0 = 1'b0;
        fc = 3'b001; siz = 2'b00; as_n = 1'b1; ds_n = 1'b1;
        cfg_we = 1'b0; cfg_slot = 2'd0; cfg_width = 2'b01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dram();
        t_slots();
        t_lanes();
        t_periph();
        t_flash();
        t_cop();
        t_unmapped();
        t_width();
        t_same_cycle();
        t_release();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule